// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of external interrupt pins and turns their activity into interrupt requests. Each pin carries a two-bit sense setting that selects low level, any change, falling edge or rising edge. In the edge settings a synchronized copy of the pin is compared with its previous sample. A detected edge sets a sticky flag. Software clears the flag by writing one to it, or the interrupt controller clears it with a per-pin acknowledge. In the low-level setting there is no flag. The request follows the synchronized pin and drops as soon as the pin goes high again.

The pin is always read from the pad, so driving the pin as an output still raises interrupts. This gives software a way to trigger its own interrupt.

While the sleep input is high, the clocked detection path is frozen. A combinational wake request instead compares the raw pin with the last stored sample, so that a qualifying edge or a low level can restart the clock. When sleep ends, a start-up window of programmable length masks level requests. A level that has gone away by the end of that window produces no request. An edge seen during sleep is recorded as a flag once the pipeline resumes.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense field (address 0), the enable register (address 1) and the flag register (address 2) all read 0, and `irq_o` and `wake_o` are low.
- R2: Writes with `reg_we_i` high update the selected register, and `reg_rdata_o` returns it at once.
  - Pin n's sense field is at bits [2n+1:2n] of address 0, with 00 = low level, 01 = any change, 10 = falling and 11 = rising.
  - Pin n's enable is bit n of address 1, and its flag is bit n of address 2.
  - Address 3 reads 0.
- R3: In low-level sense, `irq_o[n]` rises after the second clock edge that follows the pin going low, while the pin is enabled. It falls after the second edge that follows the pin going high, and no flag is set.
- R4: In falling sense, a high-to-low pin transition sets flag n after the third clock edge, and `irq_o[n]` follows it. A rising transition sets nothing.
- R5: In rising sense, only a low-to-high transition sets the flag, with the same three-edge latency.
- R6: In any-change sense, both directions of transition set the flag.
- R7: Writing 1 to bit n of address 2 clears flag n. Writing 0 leaves it unchanged.
- R8: A one-cycle pulse on `ack_i[n]` clears flag n.
- R9: When an edge sets flag n in the same cycle as a write-one clear, the flag stays set.
- R10: When the enable is 0, the flag is still set by an edge, but `irq_o[n]` stays low.
- R11: While `sleep_i` is high, the clocked path holds and `wake_o` goes high combinationally for an enabled pin whose raw value meets its sense setting. After sleep ends, an edge seen during sleep sets the flag three edges later, and `wake_o` is low whenever `sleep_i` is low.
- R12: After `sleep_i` falls, level requests are masked until `wake_delay_i` edges after the first edge with sleep low. A pin still low then raises `irq_o`; a pin that returned high raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw pad values of the interrupt pins |
| sleep_i | input | 1 | High while the clock is considered stopped |
| wake_delay_i | input | CNT_W | Start-up window length in cycles |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| ack_i | input | NUM_PINS | Per-pin interrupt acknowledge, clears the flag |
| irq_o | output | NUM_PINS | Per-pin interrupt request |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The edge detector's flag set and the write-one clear can land on the same clock edge. The bench provokes this by dropping the pin and issuing the clear write two cycles later. At that point the synchronized edge is being recorded. Reading the flag back as 1 shows that setting wins. A control clear with no edge in flight then reads back 0, which shows that the clear itself works.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stg_q[s] <= 1'b1;
      else if (!hold_i) stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_startup.sv
module eirq_startup #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             mask_o
);
  logic             sleep_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sleep_q <= sleep_i;
      if (sleep_q && !sleep_i) cnt_q <= delay_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign mask_o = sleep_i | sleep_q | (cnt_q != '0);
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e mode_i,
  input  logic   en_i,
  input  logic   pin_i,
  input  logic   hold_i,
  input  logic   lvl_mask_i,
  input  logic   clr_i,
  output logic   set_o,
  output logic   flag_o,
  output logic   irq_o,
  output logic   wake_o
);
  logic pin_s, prev_q, flag_q;

  function automatic logic edge_hit(sense_e m, logic cur, logic old);
    case (m)
      SENSE_ANY:  return cur ^ old;
      SENSE_FALL: return old & ~cur;
      SENSE_RISE: return ~old & cur;
      default:    return 1'b0;
    endcase
  endfunction

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold_i),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= 1'b1;
    else if (!hold_i) prev_q <= pin_s;
  end

  assign set_o = !hold_i && edge_hit(mode_i, pin_s, prev_q);

  // set has priority over any clear source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_o)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = en_i & ((mode_i == SENSE_LOW) ? (~pin_s & ~lvl_mask_i) : flag_q);
  // raw pad vs held sample: usable with the clock stopped
  assign wake_o = hold_i & en_i &
                  ((mode_i == SENSE_LOW) ? ~pin_i : edge_hit(mode_i, pin_i, prev_q));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eirq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                sleep_i,
  input  logic [CNT_W-1:0]    wake_delay_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                wake_o
);
  localparam int MODE_W = 2 * NUM_PINS;

  logic [MODE_W-1:0]   mode_q;
  logic [NUM_PINS-1:0] en_q, flag_q, edge_set, clr, wake_pin;
  logic                lvl_mask;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_MODE) mode_q <= reg_wdata_i[MODE_W-1:0];
      if (reg_addr_i == ADDR_EN)   en_q   <= reg_wdata_i[NUM_PINS-1:0];
    end
  end

  assign clr = ack_i |
               ((reg_we_i && reg_addr_i == ADDR_FLAG) ? reg_wdata_i[NUM_PINS-1:0] : '0);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_MODE: reg_rdata_o[MODE_W-1:0]   = mode_q;
      ADDR_EN:   reg_rdata_o[NUM_PINS-1:0] = en_q;
      ADDR_FLAG: reg_rdata_o[NUM_PINS-1:0] = flag_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  eirq_startup #(.CNT_W(CNT_W)) u_startup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sleep_i(sleep_i),
    .delay_i(wake_delay_i),
    .mask_o (lvl_mask)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    eirq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (sense_e'(mode_q[2*n +: 2])),
      .en_i      (en_q[n]),
      .pin_i     (pin_i[n]),
      .hold_i    (sleep_i),
      .lvl_mask_i(lvl_mask),
      .clr_i     (clr[n]),
      .set_o     (edge_set[n]),
      .flag_o    (flag_q[n]),
      .irq_o     (irq_o[n]),
      .wake_o    (wake_pin[n])
    );
  end

  assign wake_o = |wake_pin;
endmodule

// File: rtl/eirq_sva.sv
module eirq_sva #(
  parameter int NUM_PINS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sleep_i,
  input logic                  wake_o,
  input logic                  reg_we_i,
  input logic [1:0]            reg_addr_i,
  input logic [NUM_PINS-1:0]   wdata_lo,
  input logic [NUM_PINS-1:0]   ack_i,
  input logic [NUM_PINS-1:0]   irq_o,
  input logic [NUM_PINS-1:0]   en_q,
  input logic [2*NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0]   flag_q,
  input logic [NUM_PINS-1:0]   edge_set,
  input logic                  lvl_mask
);
  assert_irq_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~en_q) == '0);

  assert_wake_only_asleep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> !wake_o);

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_set[n] |=> flag_q[n]);

    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == 2'd2 && wdata_lo[n] && !edge_set[n]) |=> !flag_q[n]);

    assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[n] && !edge_set[n]) |=> !flag_q[n]);

    assert_startup_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_mask && mode_q[2*n +: 2] == 2'b00) |-> !irq_o[n]);

    assert_level_no_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[2*n +: 2] == 2'b00) |-> !edge_set[n]);
  end
endmodule

bind ext_irq_sense eirq_sva #(.NUM_PINS(NUM_PINS)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .wake_o    (wake_o),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .wdata_lo  (reg_wdata_i[NUM_PINS-1:0]),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .flag_q    (flag_q),
  .edge_set  (edge_set),
  .lvl_mask  (lvl_mask)
);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;
  localparam int NP = 2;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '1;
  logic          sleep = 1'b0;
  logic [CW-1:0] wdly = 8'd5;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NP-1:0] ack = '0;
  logic [NP-1:0] irq;
  logic          wake;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];
  event chk_ev;

  always #2 clk = ~clk;

  ext_irq_sense dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sleep_i(sleep),
    .wake_delay_i(wdly), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack),
    .irq_o(irq), .wake_o(wake)
  );

  // monitor: pop expected items and compare with the observed port
  always begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {6'd0, irq};
        1:       act = {7'd0, wake};
        default: act = rdata;
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(int kind, logic [1:0] a, logic [7:0] e, string req);
    if (kind == 2) addr = a;
    #0.1;
    q.push_back('{kind, e, req});
    -> chk_ev;
    #0.05;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc(1);
    we = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    expect_v(2, 2'd0, 8'h00, "R1");
    expect_v(2, 2'd1, 8'h00, "R1");
    expect_v(2, 2'd2, 8'h00, "R1");
    expect_v(0, 2'd0, 8'h00, "R1");
    expect_v(1, 2'd0, 8'h00, "R1");

    // R2 registers: pin0 falling, pin1 rising, both enabled
    wr(2'd0, 8'h0E);
    expect_v(2, 2'd0, 8'h0E, "R2");
    wr(2'd1, 8'h03);
    expect_v(2, 2'd1, 8'h03, "R2");
    expect_v(2, 2'd3, 8'h00, "R2");

    // R4 falling edge, three-edge latency
    pin[0] = 1'b0;
    cyc(2);
    expect_v(0, 2'd0, 8'h00, "R4");
    cyc(1);
    expect_v(0, 2'd0, 8'h01, "R4");
    expect_v(2, 2'd2, 8'h01, "R4");
    pin[0] = 1'b1;
    cyc(3);
    expect_v(2, 2'd2, 8'h01, "R4");

    // R7 write-one clear
    wr(2'd2, 8'h00);
    expect_v(2, 2'd2, 8'h01, "R7");
    wr(2'd2, 8'h01);
    expect_v(2, 2'd2, 8'h00, "R7");
    expect_v(0, 2'd0, 8'h00, "R7");

    // R5 rising on pin1
    pin[1] = 1'b0;
    cyc(3);
    expect_v(2, 2'd2, 8'h00, "R5");
    pin[1] = 1'b1;
    cyc(3);
    expect_v(0, 2'd0, 8'h02, "R5");
    expect_v(2, 2'd2, 8'h02, "R5");
    wr(2'd2, 8'h02);

    // R8 acknowledge clears
    pin[0] = 1'b0;
    cyc(3);
    expect_v(2, 2'd2, 8'h01, "R8");
    ack = 2'b01;
    cyc(1);
    ack = 2'b00;
    expect_v(2, 2'd2, 8'h00, "R8");
    pin[0] = 1'b1;
    cyc(3);

    // R6 any change
    wr(2'd0, 8'h0D);
    pin[0] = 1'b0;
    cyc(3);
    expect_v(2, 2'd2, 8'h01, "R6");
    wr(2'd2, 8'h01);
    pin[0] = 1'b1;
    cyc(3);
    expect_v(2, 2'd2, 8'h01, "R6");
    wr(2'd2, 8'h01);

    // R3 low level, not latched
    wr(2'd0, 8'h0C);
    pin[0] = 1'b0;
    cyc(1);
    expect_v(0, 2'd0, 8'h00, "R3");
    cyc(1);
    expect_v(0, 2'd0, 8'h01, "R3");
    expect_v(2, 2'd2, 8'h00, "R3");
    pin[0] = 1'b1;
    cyc(1);
    expect_v(0, 2'd0, 8'h01, "R3");
    cyc(1);
    expect_v(0, 2'd0, 8'h00, "R3");

    // R10 disabled pin still flags
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h0E);
    pin[0] = 1'b0;
    cyc(3);
    expect_v(0, 2'd0, 8'h00, "R10");
    expect_v(2, 2'd2, 8'h01, "R10");
    pin[0] = 1'b1;
    cyc(3);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h03);

    // R9 set coincides with write-one clear
    pin[0] = 1'b0;
    cyc(3);
    pin[0] = 1'b1;
    cyc(3);
    expect_v(2, 2'd2, 8'h01, "R9");
    pin[0] = 1'b0;
    cyc(2);
    wr(2'd2, 8'h01);
    expect_v(2, 2'd2, 8'h01, "R9");
    wr(2'd2, 8'h01);
    expect_v(2, 2'd2, 8'h00, "R9");
    pin[0] = 1'b1;
    cyc(3);

    // R11 edge wake during sleep
    sleep = 1'b1;
    expect_v(1, 2'd0, 8'h00, "R11");
    pin[0] = 1'b0;
    expect_v(1, 2'd0, 8'h01, "R11");
    cyc(4);
    expect_v(2, 2'd2, 8'h00, "R11");
    sleep = 1'b0;
    expect_v(1, 2'd0, 8'h00, "R11");
    cyc(3);
    expect_v(2, 2'd2, 8'h01, "R11");
    wr(2'd2, 8'h01);
    pin[0] = 1'b1;
    cyc(8);

    // R12 level wake, pin held through start-up
    wr(2'd0, 8'h0C);
    sleep = 1'b1;
    pin[0] = 1'b0;
    expect_v(1, 2'd0, 8'h01, "R12");
    cyc(2);
    sleep = 1'b0;
    cyc(5);
    expect_v(0, 2'd0, 8'h00, "R12");
    cyc(1);
    expect_v(0, 2'd0, 8'h01, "R12");
    pin[0] = 1'b1;
    cyc(2);
    expect_v(0, 2'd0, 8'h00, "R12");

    // R12 level gone before start-up ends
    sleep = 1'b1;
    pin[0] = 1'b0;
    expect_v(1, 2'd0, 8'h01, "R12");
    cyc(2);
    sleep = 1'b0;
    cyc(2);
    pin[0] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      expect_v(0, 2'd0, 8'h00, "R12");
    end
    expect_v(2, 2'd2, 8'h00, "R12");

    cyc(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule